// File: doc/BRIEF.md
# Programmable Peripheral Clock-Enable Divider

This block turns one fast system clock into a set of single-cycle clock-enable strobes for downstream logic. It does not produce derived clocks: every output is a one-cycle-wide enable pulse in the system clock domain. Consumers qualify their own flops with these pulses. Two core channels count system clock cycles with a power-of-two ratio. Three peripheral channels count enable pulses from one of two incoming sources, an oscillator-rate enable and a bus-rate enable, and divide them by an even ratio.

A simple write port and a combinational read port program the block through seven byte-wide registers. Each peripheral channel has a stop bit, where 1 halts the channel and 0 lets it run, and a source-select bit. Every channel is built around the same three-state machine. `ST_IDLE` is the stopped or just-reset state, where the channel loads its ratio. `ST_PASS` forwards every source enable. `ST_COUNT` counts source enables up to the terminal count. The named transitions are:
- **start**: `ST_IDLE` to `ST_PASS` or `ST_COUNT`, taken when the stop bit is clear, chosen by the ratio.
- **reload**: at each terminal count, `ST_PASS` or `ST_COUNT` moves to `ST_PASS` or `ST_COUNT`, again chosen by the newly sampled ratio.
- **halt**: any state to `ST_IDLE`, taken while the stop bit is 1.

Top module: `ckd_top`

## Requirements
- R1: A core channel with prescale field N (register 0 or 1, bits 3:0) emits exactly one strobe every 2^N system clock cycles. With N=0 it strobes every cycle.
- R2: A peripheral channel with field V>0 (registers 2, 3, 4, bits 7:0) emits one strobe for every 2·V enables of its selected source. So V=16 divides by 32 and V=128 divides by 256.
- R3: A peripheral channel with V=0 forwards every selected source enable.
- R4: A strobe is high for one cycle, in the cycle after the source enable that completes the count. No strobe appears without a source enable.
- R5: The stop register (address 5) holds bit i for peripheral channel i. Writing 1 forces that channel's strobe low from the second cycle after the write onwards. Writing 0 restarts the channel with its count at zero.
- R6: The select register (address 6) holds bit i for peripheral channel i. For channels 0 and 1, 0 picks the oscillator enable and 1 picks the bus enable. For channel 2 the sense is inverted: 0 picks the bus enable and 1 picks the oscillator enable.
- R7: A changed prescale value is adopted only at the channel's next terminal count. The period already in progress finishes at the old ratio.
- R8: After reset every prescale field, stop bit and select bit is 0. All channels run, and the core channels strobe every cycle.
- R9: A read at address 0 to 6 returns the stored field, zero-extended. Bits beyond a field's width are discarded on write. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| osc_tick | input | 1 | Oscillator-rate enable source |
| bus_tick | input | 1 | Bus-rate enable source |
| core_stb | output | 2 | Core channel strobes, bit i for core channel i |
| peri_stb | output | 3 | Peripheral channel strobes, bit i for peripheral channel i |

## Verification
The in-line assertions check four properties on every cycle:
- the count never reaches its ratio;
- pass mode only runs at unit ratio;
- no strobe follows a cycle without a source enable;
- a stopped channel stays silent, and register writes land.

Other behaviour needs the bench's scenarios, which compare every strobe against a cycle-accurate model built from the requirements. These scenarios cover:
- the exact strobe spacing at each ratio, including 2^15 and 510;
- deferral of a mid-period ratio change to the terminal count;
- the inverted select sense on the third channel;
- the restart from zero after a stop is released.

// File: rtl/ckd_pkg.sv
package ckd_pkg;

    // Per-channel divider states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // stopped or just reset: loads the ratio
        ST_PASS  = 2'd1,   // unit ratio: every source enable fires
        ST_COUNT = 2'd2    // counting source enables to terminal
    } chan_state_e;

endpackage

// File: rtl/ckd_regs.sv
module ckd_regs #(
    parameter int N_CORE = 2,
    parameter int N_PERI = 3,
    parameter int CORE_W = 4,
    parameter int PERI_W = 8,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [DATA_W-1:0]              rd_data,
    output logic [N_CORE-1:0][CORE_W-1:0]  core_pre_o,
    output logic [N_PERI-1:0][PERI_W-1:0]  peri_pre_o,
    output logic [N_PERI-1:0]              stop_o,
    output logic [N_PERI-1:0]              sel_o
);

    localparam int PERI_BASE = N_CORE;
    localparam int STOP_ADDR = N_CORE + N_PERI;
    localparam int SEL_ADDR  = STOP_ADDR + 1;

    logic [N_CORE-1:0][CORE_W-1:0] core_q;
    logic [N_PERI-1:0][PERI_W-1:0] peri_q;
    logic [N_PERI-1:0]             stop_q;
    logic [N_PERI-1:0]             sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
            peri_q <= '0;
            stop_q <= '0;
            sel_q  <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < N_CORE; i++) begin
                if (wr_addr == ADDR_W'(i))
                    core_q[i] <= wr_data[CORE_W-1:0];
            end
            for (int j = 0; j < N_PERI; j++) begin
                if (wr_addr == ADDR_W'(PERI_BASE + j))
                    peri_q[j] <= wr_data[PERI_W-1:0];
            end
            if (wr_addr == ADDR_W'(STOP_ADDR))
                stop_q <= wr_data[N_PERI-1:0];
            if (wr_addr == ADDR_W'(SEL_ADDR))
                sel_q <= wr_data[N_PERI-1:0];
        end
    end

    // Read mux: unmapped addresses return zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_CORE; i++) begin
            if (rd_addr == ADDR_W'(i))
                rd_data = DATA_W'(core_q[i]);
        end
        for (int j = 0; j < N_PERI; j++) begin
            if (rd_addr == ADDR_W'(PERI_BASE + j))
                rd_data = DATA_W'(peri_q[j]);
        end
        if (rd_addr == ADDR_W'(STOP_ADDR))
            rd_data = DATA_W'(stop_q);
        if (rd_addr == ADDR_W'(SEL_ADDR))
            rd_data = DATA_W'(sel_q);
    end

    assign core_pre_o = core_q;
    assign peri_pre_o = peri_q;
    assign stop_o     = stop_q;
    assign sel_o      = sel_q;

    AST_STOP_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(STOP_ADDR)) |=> (stop_o == $past(wr_data[N_PERI-1:0]))); // R5

    AST_SEL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(SEL_ADDR)) |=> (sel_o == $past(wr_data[N_PERI-1:0]))); // R6

    AST_IDLE_BUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(stop_o) && $stable(sel_o)); // R9

endmodule

// File: rtl/ckd_srcsel.sv
module ckd_srcsel #(
    parameter int                N_PERI  = 3,
    parameter logic [N_PERI-1:0] SEL_INV = 3'b100
) (
    input  logic              osc_tick,
    input  logic              bus_tick,
    input  logic [N_PERI-1:0] sel_i,
    output logic [N_PERI-1:0] tick_o
);

    for (genvar g = 0; g < N_PERI; g++) begin : g_pick
        if (SEL_INV[g]) begin : g_inv
            // inverted sense: 0 -> bus, 1 -> oscillator
            assign tick_o[g] = sel_i[g] ? osc_tick : bus_tick;
        end else begin : g_norm
            // normal sense: 0 -> oscillator, 1 -> bus
            assign tick_o[g] = sel_i[g] ? bus_tick : osc_tick;
        end
    end

    always_comb begin
        if (!osc_tick && !bus_tick)
            AST_NO_PHANTOM_TICK: assert (tick_o == '0); // R6
    end

endmodule

// File: rtl/ckd_chan.sv
module ckd_chan
    import ckd_pkg::*;
#(
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,    // source enable
    input  logic               halt_i,    // 1 = channel stopped
    input  logic [RATIO_W-1:0] ratio_i,   // programmed divide ratio
    output logic               strobe_o
);

    chan_state_e        state_q, state_d;
    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic [RATIO_W-1:0] act_q, act_d;   // ratio in force for this period
    logic               fire;
    logic               unit_ratio;
    logic               strobe_q;

    assign unit_ratio = (ratio_i <= RATIO_W'(1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            act_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
        end
    end

    // Next state: start, reload, halt
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        act_d   = act_q;
        fire    = 1'b0;
        if (halt_i) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    act_d   = ratio_i;
                    cnt_d   = '0;
                    state_d = unit_ratio ? ST_PASS : ST_COUNT;
                end
                ST_PASS: begin
                    if (tick_i) begin
                        fire    = 1'b1;
                        act_d   = ratio_i;
                        cnt_d   = '0;
                        state_d = unit_ratio ? ST_PASS : ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (tick_i) begin
                        if (cnt_q == act_q - RATIO_W'(1)) begin
                            fire    = 1'b1;
                            act_d   = ratio_i;
                            cnt_d   = '0;
                            state_d = unit_ratio ? ST_PASS : ST_COUNT;
                        end else begin
                            cnt_d = cnt_q + RATIO_W'(1);
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_q <= 1'b0;
        else
            strobe_q <= fire;
    end

    assign strobe_o = strobe_q;

    AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (cnt_q < act_q)); // R2

    AST_PASS_AT_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS) |-> (act_q <= RATIO_W'(1))); // R3

    AST_TICK_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !strobe_o); // R4

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> !strobe_o); // R5

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !strobe_o); // R5

    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !tick_i && !halt_i) |=> $stable(act_q)); // R7

endmodule

// File: rtl/ckd_top.sv
module ckd_top #(
    parameter int                N_CORE  = 2,
    parameter int                N_PERI  = 3,
    parameter int                CORE_W  = 4,
    parameter int                PERI_W  = 8,
    parameter int                ADDR_W  = 3,
    parameter int                DATA_W  = 8,
    parameter logic [N_PERI-1:0] SEL_INV = 3'b100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              osc_tick,
    input  logic              bus_tick,
    output logic [N_CORE-1:0] core_stb,
    output logic [N_PERI-1:0] peri_stb
);

    localparam int CORE_RW = (1 << CORE_W);
    localparam int PERI_RW = PERI_W + 1;
    localparam int RATIO_W = (CORE_RW > PERI_RW) ? CORE_RW : PERI_RW;

    logic [N_CORE-1:0][CORE_W-1:0] core_pre;
    logic [N_PERI-1:0][PERI_W-1:0] peri_pre;
    logic [N_PERI-1:0]             stop;
    logic [N_PERI-1:0]             sel;
    logic [N_PERI-1:0]             peri_tick;

    ckd_regs #(
        .N_CORE (N_CORE),
        .N_PERI (N_PERI),
        .CORE_W (CORE_W),
        .PERI_W (PERI_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .core_pre_o (core_pre),
        .peri_pre_o (peri_pre),
        .stop_o     (stop),
        .sel_o      (sel)
    );

    ckd_srcsel #(
        .N_PERI  (N_PERI),
        .SEL_INV (SEL_INV)
    ) u_srcsel (
        .osc_tick (osc_tick),
        .bus_tick (bus_tick),
        .sel_i    (sel),
        .tick_o   (peri_tick)
    );

    // Core channels: count system cycles, ratio 2^N, never stopped
    for (genvar c = 0; c < N_CORE; c++) begin : g_core
        logic [RATIO_W-1:0] ratio;
        assign ratio = RATIO_W'(1) << core_pre[c];

        ckd_chan #(.RATIO_W(RATIO_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (1'b1),
            .halt_i   (1'b0),
            .ratio_i  (ratio),
            .strobe_o (core_stb[c])
        );
    end

    // Peripheral channels: count selected enables, ratio 2V (V=0 -> 1)
    for (genvar p = 0; p < N_PERI; p++) begin : g_peri
        logic [RATIO_W-1:0] ratio;
        assign ratio = (peri_pre[p] == '0) ? RATIO_W'(1)
                                           : RATIO_W'({peri_pre[p], 1'b0});

        ckd_chan #(.RATIO_W(RATIO_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (peri_tick[p]),
            .halt_i   (stop[p]),
            .ratio_i  (ratio),
            .strobe_o (peri_stb[p])
        );
    end

    AST_CORE_UNIT_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (core_stb == '0)); // R8

    AST_STOPPED_PERI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop[0]) && stop[0] |-> !peri_stb[0]); // R5

endmodule

// File: tb/sim_ckd_top.sv
module sim_ckd_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       osc_tick = 1'b0;
    logic       bus_tick = 1'b0;
    logic [1:0] core_stb;
    logic [2:0] peri_stb;

    always #4 clk = ~clk;   // 125 MHz

    ckd_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .osc_tick (osc_tick),
        .bus_tick (bus_tick),
        .core_stb (core_stb),
        .peri_stb (peri_stb)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    string phase    = "R8";

    logic [4:0] exp_q[$];

    // Shadow of programmed registers
    int sh_core[2];
    int sh_peri[3];
    bit [2:0] sh_stop;
    bit [2:0] sh_sel;

    // Reference model state per channel: 0 idle, 1 pass, 2 count
    int m_st[5];
    int m_cnt[5];
    int m_act[5];

    task automatic model_step(input int ch, input bit tick, input bit halt,
                              input int ratio, output bit fire);
        fire = 0;
        if (halt) begin
            m_st[ch]  = 0;
            m_cnt[ch] = 0;
        end else if (m_st[ch] == 0) begin
            m_act[ch] = ratio;
            m_cnt[ch] = 0;
            m_st[ch]  = (ratio <= 1) ? 1 : 2;
        end else if (tick) begin
            if (m_st[ch] == 1 || m_cnt[ch] == m_act[ch] - 1) begin
                fire      = 1;
                m_act[ch] = ratio;
                m_cnt[ch] = 0;
                m_st[ch]  = (ratio <= 1) ? 1 : 2;
            end else begin
                m_cnt[ch] = m_cnt[ch] + 1;
            end
        end
    endtask

    // Driver: one cycle of stimulus, expected strobes pushed to the scoreboard
    task automatic step(input bit osc, input bit bus, input bit wr,
                        input int addr, input int data);
        logic [4:0] e;
        bit f;
        @(negedge clk);
        #1;
        rst_n    = 1'b1;
        osc_tick = osc;
        bus_tick = bus;
        wr_en    = wr;
        wr_addr  = 3'(addr);
        wr_data  = 8'(data);
        for (int c = 0; c < 2; c++) begin
            model_step(c, 1'b1, 1'b0, 1 << sh_core[c], f);
            e[c] = f;
        end
        for (int p = 0; p < 3; p++) begin
            bit pick_bus;
            bit tk;
            int r;
            pick_bus = (p == 2) ? !sh_sel[p] : sh_sel[p];
            tk = pick_bus ? bus : osc;
            r  = (sh_peri[p] == 0) ? 1 : 2 * sh_peri[p];
            model_step(2 + p, tk, sh_stop[p], r, f);
            e[2 + p] = f;
        end
        exp_q.push_back(e);
        if (wr) begin
            if (addr < 2)       sh_core[addr] = data & 15;
            else if (addr < 5)  sh_peri[addr - 2] = data & 255;
            else if (addr == 5) sh_stop = 3'(data);
            else if (addr == 6) sh_sel = 3'(data);
        end
    endtask

    task automatic run(input int n, input int osc_pct, input int bus_pct);
        for (int k = 0; k < n; k++)
            step(($urandom % 100) < osc_pct, ($urandom % 100) < bus_pct, 0, 0, 0);
    endtask

    task automatic wr(input int addr, input int data);
        step($urandom % 2, $urandom % 2, 1, addr, data);
    endtask

    task automatic rd_chk(input int addr, input int exp, input string req);
        rd_addr = 3'(addr);
        #1;
        n_checks++;
        if (rd_data !== 8'(exp)) begin
            n_fails++;
            $display("FAIL %s read addr %0d actual %0h expected %0h", req, addr, rd_data, exp);
        end
    endtask

    // Monitor: pops the scoreboard and compares observed strobes
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [4:0] e;
            e = exp_q.pop_front();
            n_checks++;
            if ({peri_stb, core_stb} !== e) begin
                n_fails++;
                $display("FAIL %s strobes actual %b expected %b at %0t", phase,
                         {peri_stb, core_stb}, e, $time);
            end
        end
    end

    task automatic finish_up();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired in phase %s", phase);
            finish_up();
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) begin
            m_st[i] = 0; m_cnt[i] = 0; m_act[i] = 0;
        end
        for (int i = 0; i < 2; i++) sh_core[i] = 0;
        for (int i = 0; i < 3; i++) sh_peri[i] = 0;
        sh_stop = '0;
        sh_sel  = '0;
        repeat (4) @(posedge clk);

        // R8 / R9: reset values read back as zero
        for (int a = 0; a < 8; a++) rd_chk(a, 0, "R8");

        // R8 + R3: reset ratios, core every cycle, peripherals forward enables
        phase = "R3";
        run(40, 50, 50);

        // R4: sparse enables, one-cycle strobes only after an enable
        phase = "R4";
        run(60, 10, 15);

        // R9: field widths and readback
        phase = "R9";
        wr(1, 8'hFF);
        wr(0, 3);
        wr(2, 2);
        run(1, 0, 0);
        rd_chk(1, 8'h0F, "R9");
        rd_chk(0, 3, "R9");
        rd_chk(2, 2, "R9");
        rd_chk(7, 0, "R9");

        // R1 + R2: divided ratios, sources on bus for channels 0,1 and 2
        phase = "R2";
        wr(1, 5);
        wr(3, 1);
        wr(4, 3);
        wr(6, 3'b011);
        run(400, 60, 40);

        // R6: select swap, channel 2 uses inverted sense
        phase = "R6";
        wr(6, 3'b100);
        run(200, 70, 20);
        wr(6, 3'b010);
        run(200, 30, 80);
        rd_chk(6, 3'b010, "R6");

        // R7: change ratios mid-period
        phase = "R7";
        wr(4, 10);
        run(7, 50, 50);
        wr(2, 5);
        wr(0, 6);
        run(5, 50, 50);
        wr(0, 1);
        run(300, 60, 60);

        // R5: stop channel 1, then release and restart from zero
        phase = "R5";
        wr(5, 3'b010);
        run(100, 60, 60);
        rd_chk(5, 3'b010, "R5");
        wr(5, 3'b111);
        run(50, 90, 90);
        wr(5, 0);
        run(150, 60, 60);

        // R2 boundary: largest peripheral ratios, enables every cycle
        phase = "R2";
        wr(2, 255);
        wr(4, 128);
        wr(3, 16);
        run(1200, 100, 100);

        // R1 boundary: largest core ratio 2^15
        phase = "R1";
        wr(1, 15);
        wr(0, 0);
        run(66000, 50, 50);

        @(negedge clk);
        #1;
        finish_up();
    end

endmodule